// File: doc/BRIEF.md
# PCI Target Configuration Header

This block is the Type 0 configuration header of a single-function PCI target that is reached through memory space. It sits behind a simple configuration-access port that carries a dword index, byte enables, write data and one-cycle read and write strobes. It answers reads with a registered data word one cycle later. It holds the identity words and the command and status bits, and it owns one memory base address register that claims a 4 KB window. Every register it does not implement reads back as zero.

The identity words do not come from constants. After reset a small controller sits in state `ST_PRELOAD`. In that state a nonvolatile loader writes the vendor/device word and the subsystem word through a dedicated preload port. When the loader raises `ld_done`, the transition `PRELOAD_DONE` moves the controller to `ST_ACTIVE`, and it stays there until the next reset (transition `RESET_ENTRY`). While the controller is in `ST_PRELOAD`, configuration accesses are refused. Once it is in `ST_ACTIVE`, the identity words are frozen.

The block also reports when an incoming memory address falls inside the claimed window. The command enable bits for error signalling are brought out to the rest of the target.

Top module: `cfghdr_top`

## Requirements
- R1: After reset the controller is in `ST_PRELOAD` and `cfg_ready` is 0. Once it is active, the command word reads 0, the BAR reads 0, the interrupt line reads 0, and the status half of dword 1 reads only bit 23 set, giving 0x0080_0000.
- R2: In `ST_PRELOAD`, a pulse on `ld_we` with `ld_sel`=0 loads dword 0x00 (device ID in bits 31:16, vendor ID in bits 15:0). With `ld_sel`=1 it loads dword 0x0B, byte offset 0x2C (subsystem ID in bits 31:16, subsystem vendor ID in bits 15:0). Without a preload, both words read 0.
- R3: After `ld_done`, the controller stays in `ST_ACTIVE` until reset. In that state, preload pulses and configuration writes to dwords 0x00 and 0x0B leave the identity words unchanged.
- R4: While `cfg_ready` is 0, a configuration write changes nothing, and a configuration read produces no `cfg_rvalid`.
- R5: A read accepted on an edge puts its word on `cfg_rdata`, with `cfg_rvalid` high, after that same edge.
- R6: Command dword 1, bits 15:0: bit 8 (SERR driver enable) is written through byte enable 1, and bits 6 (parity response) and 1 (memory enable) through byte enable 0. Bit 0 (I/O enable) and all other command bits read 0 and ignore writes. Bits 8 and 6 drive `serr_en` and `perr_en`.
- R7: Status bits 31 (parity error seen), 30 (system error seen) and 27 (target abort signalled) are set by `par_err_evt`, `sys_err_evt` and `tabort_evt`. Each clears when its bit is written as 1 with byte enable 3. Writing 0 leaves it set. A set event wins over a clear in the same cycle.
- R8: Status bit 23 always reads 1. Every other status bit not named in R7 reads 0.
- R9: Dword 0x02 reads class code 0x070002 in bits 31:8 and revision 0x01 in bits 7:0. Dword 0x03 reads 0. Both ignore writes.
- R10: BAR dword 0x04 stores bits 31:12, byte by byte under its byte enables. Bits 11:0 always read 0.
- R11: Dwords 0x05–0x0A, 0x0C–0x0E and 0x10–0x3F read 0 whatever is written to them.
- R12: Dword 0x0F reads interrupt pin 0x01 in bits 15:8 and a writable interrupt line in bits 7:0, written under byte enable 0. Bits 31:16 read 0.
- R13: `mem_hit` is 1 exactly when the memory enable bit is set and `mem_addr_hi` equals BAR bits 31:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Byte enables, active high |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_wr | input | 1 | Write strobe, one cycle |
| cfg_rd | input | 1 | Read strobe, one cycle |
| cfg_rdata | output | 32 | Registered read data |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_ready | output | 1 | Header active, accesses accepted |
| ld_we | input | 1 | Preload write strobe |
| ld_sel | input | 1 | Preload target: 0 identity, 1 subsystem |
| ld_data | input | 32 | Preload word |
| ld_done | input | 1 | Loader finished |
| par_err_evt | input | 1 | Parity error event |
| sys_err_evt | input | 1 | System error event |
| tabort_evt | input | 1 | Target abort event |
| mem_addr_hi | input | 20 | Memory address bits 31:12 to decode |
| mem_hit | output | 1 | Address falls in the claimed window |
| serr_en | output | 1 | SERR driver enable |
| perr_en | output | 1 | Parity response enable |

## Verification
The hardest situations to reach are a set event and a write-1-to-clear on the same status bit in the same cycle, and the freezing of the identity words. The first case is driven by a directed sequence that raises the event strobe on the same cycle as the status write. Freezing can only be observed by cycling through reset, first without a preload and then with one. After that, late preload pulses and config writes to the identity dwords are issued and the words are read back. Random writes with random byte enables then cover the byte-merge paths of the command, BAR and interrupt-line fields against a bench model.

// File: rtl/cfghdr_pkg.sv
package cfghdr_pkg;

    localparam int CFG_AW = 6;

    typedef enum logic [0:0] {
        ST_PRELOAD = 1'b0,
        ST_ACTIVE  = 1'b1
    } hdr_state_e;

    localparam logic [CFG_AW-1:0] IDX_IDENT  = 6'h00;
    localparam logic [CFG_AW-1:0] IDX_CMDSTA = 6'h01;
    localparam logic [CFG_AW-1:0] IDX_CLASS  = 6'h02;
    localparam logic [CFG_AW-1:0] IDX_HDR    = 6'h03;
    localparam logic [CFG_AW-1:0] IDX_BAR0   = 6'h04;
    localparam logic [CFG_AW-1:0] IDX_SUBSYS = 6'h0B;
    localparam logic [CFG_AW-1:0] IDX_INTR   = 6'h0F;

    function automatic logic [31:0] be_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be);
        logic [31:0] res;
        for (int b = 0; b < 4; b++) begin
            res[b*8 +: 8] = be[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/cfghdr_ctrl.sv
module cfghdr_ctrl
    import cfghdr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ld_done,
    input  logic ld_we,
    input  logic cfg_wr,
    input  logic cfg_rd,
    output logic ready,
    output logic wr_ok,
    output logic rd_ok,
    output logic ld_ok
);

    hdr_state_e state_q, state_d;

    // state register; RESET_ENTRY forces ST_PRELOAD
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PRELOAD;
        else        state_q <= state_d;
    end

    // next state: PRELOAD_DONE is the only transition
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRELOAD: if (ld_done) state_d = ST_ACTIVE;
            ST_ACTIVE:  state_d = ST_ACTIVE;
            default:    state_d = ST_PRELOAD;
        endcase
    end

    // access qualification per state
    always_comb begin
        ready = 1'b0;
        wr_ok = 1'b0;
        rd_ok = 1'b0;
        ld_ok = 1'b0;
        unique case (state_q)
            ST_PRELOAD: ld_ok = ld_we;
            ST_ACTIVE: begin
                ready = 1'b1;
                wr_ok = cfg_wr;
                rd_ok = cfg_rd;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cfghdr_regs.sv
module cfghdr_regs
    import cfghdr_pkg::*;
#(
    parameter int BAR_LSB = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_ok,
    input  logic                  ld_ok,
    input  logic                  ld_sel,
    input  logic [31:0]           ld_data,
    input  logic [CFG_AW-1:0]     addr,
    input  logic [3:0]            be,
    input  logic [31:0]           wdata,
    input  logic                  par_err_evt,
    input  logic                  sys_err_evt,
    input  logic                  tabort_evt,
    output logic [31:0]           id_word,
    output logic [31:0]           sub_word,
    output logic [15:0]           cmd_word,
    output logic [15:0]           sta_word,
    output logic [31:BAR_LSB]     bar_base,
    output logic [7:0]            int_line
);

    localparam logic [BAR_LSB-1:0] BAR_ZERO = '0;

    logic cmd_serr_q, cmd_perr_q, cmd_mem_q;
    logic sta_perr_q, sta_serr_q, sta_tabt_q;
    logic hit_cmdsta, hit_bar, hit_intr;
    logic clr_byte;
    logic [31:0] bar_merged;

    assign hit_cmdsta = wr_ok && (addr == IDX_CMDSTA);
    assign hit_bar    = wr_ok && (addr == IDX_BAR0);
    assign hit_intr   = wr_ok && (addr == IDX_INTR);
    assign clr_byte   = hit_cmdsta && be[3];
    assign bar_merged = be_merge({bar_base, BAR_ZERO}, wdata, be);

    // identity words: written only by the loader
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_word  <= '0;
            sub_word <= '0;
        end else if (ld_ok) begin
            if (ld_sel) sub_word <= ld_data;
            else        id_word  <= ld_data;
        end
    end

    // command enables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_serr_q <= 1'b0;
            cmd_perr_q <= 1'b0;
            cmd_mem_q  <= 1'b0;
        end else if (hit_cmdsta) begin
            if (be[0]) begin
                cmd_perr_q <= wdata[6];
                cmd_mem_q  <= wdata[1];
            end
            if (be[1]) cmd_serr_q <= wdata[8];
        end
    end

    // sticky error status, write one to clear, set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sta_perr_q <= 1'b0;
            sta_serr_q <= 1'b0;
            sta_tabt_q <= 1'b0;
        end else begin
            sta_perr_q <= par_err_evt | (sta_perr_q & ~(clr_byte & wdata[31]));
            sta_serr_q <= sys_err_evt | (sta_serr_q & ~(clr_byte & wdata[30]));
            sta_tabt_q <= tabort_evt  | (sta_tabt_q & ~(clr_byte & wdata[27]));
        end
    end

    // base address and interrupt line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bar_base <= '0;
            int_line <= '0;
        end else begin
            if (hit_bar)          bar_base <= bar_merged[31:BAR_LSB];
            if (hit_intr && be[0]) int_line <= wdata[7:0];
        end
    end

    assign cmd_word = {7'b0, cmd_serr_q, 1'b0, cmd_perr_q, 4'b0, cmd_mem_q, 1'b0};
    assign sta_word = {sta_perr_q, sta_serr_q, 2'b0, sta_tabt_q, 3'b0, 1'b1, 7'b0};

endmodule

// File: rtl/cfghdr_rdmux.sv
module cfghdr_rdmux
    import cfghdr_pkg::*;
#(
    parameter int          BAR_LSB    = 12,
    parameter logic [23:0] CLASS_CODE = 24'h070002,
    parameter logic [7:0]  REV_ID     = 8'h01,
    parameter logic [7:0]  INT_PIN    = 8'h01
) (
    input  logic [CFG_AW-1:0] addr,
    input  logic [31:0]       id_word,
    input  logic [31:0]       sub_word,
    input  logic [15:0]       cmd_word,
    input  logic [15:0]       sta_word,
    input  logic [31:BAR_LSB] bar_base,
    input  logic [7:0]        int_line,
    output logic [31:0]       rd_word
);

    localparam logic [BAR_LSB-1:0] BAR_ZERO = '0;

    always_comb begin
        rd_word = '0;
        unique case (addr)
            IDX_IDENT:  rd_word = id_word;
            IDX_CMDSTA: rd_word = {sta_word, cmd_word};
            IDX_CLASS:  rd_word = {CLASS_CODE, REV_ID};
            IDX_BAR0:   rd_word = {bar_base, BAR_ZERO};
            IDX_SUBSYS: rd_word = sub_word;
            IDX_INTR:   rd_word = {16'h0, INT_PIN, int_line};
            default:    rd_word = '0;
        endcase
    end

endmodule

// File: rtl/cfghdr_top.sv
module cfghdr_top
    import cfghdr_pkg::*;
#(
    parameter int          BAR_LSB    = 12,
    parameter logic [23:0] CLASS_CODE = 24'h070002,
    parameter logic [7:0]  REV_ID     = 8'h01,
    parameter logic [7:0]  INT_PIN    = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    output logic [31:0]       cfg_rdata,
    output logic              cfg_rvalid,
    output logic              cfg_ready,
    input  logic              ld_we,
    input  logic              ld_sel,
    input  logic [31:0]       ld_data,
    input  logic              ld_done,
    input  logic              par_err_evt,
    input  logic              sys_err_evt,
    input  logic              tabort_evt,
    input  logic [31:BAR_LSB] mem_addr_hi,
    output logic              mem_hit,
    output logic              serr_en,
    output logic              perr_en
);

    logic wr_ok, rd_ok, ld_ok;
    logic [31:0] id_word, sub_word, rd_word;
    logic [15:0] cmd_word, sta_word;
    logic [31:BAR_LSB] bar_base;
    logic [7:0] int_line;

    cfghdr_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_done (ld_done),
        .ld_we   (ld_we),
        .cfg_wr  (cfg_wr),
        .cfg_rd  (cfg_rd),
        .ready   (cfg_ready),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .ld_ok   (ld_ok)
    );

    cfghdr_regs #(.BAR_LSB(BAR_LSB)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ok       (wr_ok),
        .ld_ok       (ld_ok),
        .ld_sel      (ld_sel),
        .ld_data     (ld_data),
        .addr        (cfg_addr),
        .be          (cfg_be),
        .wdata       (cfg_wdata),
        .par_err_evt (par_err_evt),
        .sys_err_evt (sys_err_evt),
        .tabort_evt  (tabort_evt),
        .id_word     (id_word),
        .sub_word    (sub_word),
        .cmd_word    (cmd_word),
        .sta_word    (sta_word),
        .bar_base    (bar_base),
        .int_line    (int_line)
    );

    cfghdr_rdmux #(
        .BAR_LSB    (BAR_LSB),
        .CLASS_CODE (CLASS_CODE),
        .REV_ID     (REV_ID),
        .INT_PIN    (INT_PIN)
    ) u_rdmux (
        .addr     (cfg_addr),
        .id_word  (id_word),
        .sub_word (sub_word),
        .cmd_word (cmd_word),
        .sta_word (sta_word),
        .bar_base (bar_base),
        .int_line (int_line),
        .rd_word  (rd_word)
    );

    // registered read return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_rdata  <= '0;
            cfg_rvalid <= 1'b0;
        end else begin
            cfg_rvalid <= rd_ok;
            if (rd_ok) cfg_rdata <= rd_word;
        end
    end

    assign mem_hit = cmd_word[1] && (mem_addr_hi == bar_base);
    assign serr_en = cmd_word[8];
    assign perr_en = cmd_word[6];

endmodule

// File: rtl/cfghdr_chk.sv
module cfghdr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  cfg_addr,
    input logic        cfg_rd,
    input logic        cfg_ready,
    input logic        cfg_rvalid,
    input logic [31:0] cfg_rdata,
    input logic        mem_hit,
    input logic        mem_en,
    input logic        par_err_evt,
    input logic        sta_perr,
    input logic [31:0] id_word
);

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_ready) |=> cfg_rvalid); // R5

    AST_NO_RD_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ready) |=> !cfg_rvalid); // R4

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |=> cfg_ready); // R3

    AST_ID_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |=> $stable(id_word)); // R3

    AST_BAR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_ready && cfg_addr == 6'h04) |=> (cfg_rdata[11:0] == 12'h0)); // R10

    AST_IOEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_ready && cfg_addr == 6'h01) |=> (cfg_rdata[0] == 1'b0 && cfg_rdata[23] == 1'b1)); // R6 R8

    AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit |-> mem_en); // R13

    AST_PERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_evt |=> sta_perr); // R7

endmodule

bind cfghdr_top cfghdr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_addr    (cfg_addr),
    .cfg_rd      (cfg_rd),
    .cfg_ready   (cfg_ready),
    .cfg_rvalid  (cfg_rvalid),
    .cfg_rdata   (cfg_rdata),
    .mem_hit     (mem_hit),
    .mem_en      (cmd_word[1]),
    .par_err_evt (par_err_evt),
    .sta_perr    (sta_word[15]),
    .id_word     (id_word)
);

// File: tb/cfghdr_top_tb_top.sv
module cfghdr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [31:0] cfg_rdata;
    logic        cfg_rvalid;
    logic        cfg_ready;
    logic        ld_we = 1'b0;
    logic        ld_sel = 1'b0;
    logic [31:0] ld_data = '0;
    logic        ld_done = 1'b0;
    logic        par_err_evt = 1'b0;
    logic        sys_err_evt = 1'b0;
    logic        tabort_evt = 1'b0;
    logic [31:12] mem_addr_hi = '0;
    logic        mem_hit;
    logic        serr_en;
    logic        perr_en;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [31:0] m_id, m_sub, m_bar;
    logic        m_serr, m_perr, m_mem;
    logic        m_spe, m_sse, m_sta;
    logic [7:0]  m_line;

    always #4 clk = ~clk;

    cfghdr_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid), .cfg_ready(cfg_ready),
        .ld_we(ld_we), .ld_sel(ld_sel), .ld_data(ld_data), .ld_done(ld_done),
        .par_err_evt(par_err_evt), .sys_err_evt(sys_err_evt), .tabort_evt(tabort_evt),
        .mem_addr_hi(mem_addr_hi), .mem_hit(mem_hit), .serr_en(serr_en), .perr_en(perr_en)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        case (a)
            6'h00: return m_id;
            6'h01: return {m_spe, m_sse, 2'b0, m_sta, 3'b0, 1'b1, 7'b0,
                           7'b0, m_serr, 1'b0, m_perr, 4'b0, m_mem, 1'b0};
            6'h02: return 32'h0700_0201;
            6'h04: return {m_bar[31:12], 12'h0};
            6'h0B: return m_sub;
            6'h0F: return {16'h0, 8'h01, m_line};
            default: return 32'h0;
        endcase
    endfunction

    function automatic void model_write(input logic [5:0] a, input logic [3:0] be,
                                        input logic [31:0] d);
        if (a == 6'h01) begin
            if (be[0]) begin m_perr = d[6]; m_mem = d[1]; end
            if (be[1]) m_serr = d[8];
            if (be[3]) begin
                if (d[31]) m_spe = 1'b0;
                if (d[30]) m_sse = 1'b0;
                if (d[27]) m_sta = 1'b0;
            end
        end else if (a == 6'h04) begin
            for (int b = 0; b < 4; b++) if (be[b]) m_bar[b*8 +: 8] = d[b*8 +: 8];
            m_bar[11:0] = 12'h0;
        end else if (a == 6'h0F) begin
            if (be[0]) m_line = d[7:0];
        end
    endfunction

    function automatic void model_reset();
        m_id = '0; m_sub = '0; m_bar = '0; m_serr = 0; m_perr = 0; m_mem = 0;
        m_spe = 0; m_sse = 0; m_sta = 0; m_line = '0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ld_done = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic go_active();
        @(negedge clk);
        ld_done = 1'b1;
        @(negedge clk);
        ld_done = 1'b0;
    endtask

    task automatic preload(input logic sel, input logic [31:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_sel = sel; ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [5:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = a;
        @(negedge clk);
        d = cfg_rdata; v = cfg_rvalid;
        cfg_rd = 1'b0;
    endtask

    task automatic read_check(input logic [5:0] a, input string tag);
        logic [31:0] d; logic v;
        cfg_read(a, d, v);
        check({31'b0, v}, 32'h1, tag);
        check(d, exp_read(a), tag);
    endtask

    task automatic hit_check(input logic [31:12] ah, input string tag);
        @(negedge clk);
        mem_addr_hi = ah;
        #1;
        check({31'b0, mem_hit}, {31'b0, m_mem && (ah == m_bar[31:12])}, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] d; logic v;
        void'($urandom(32'd715));
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: preload state after reset
        check({31'b0, cfg_ready}, 32'h0, "R1 ready low after reset");
        // R4: accesses refused during preload
        cfg_write(6'h0F, 4'hF, 32'h0000_0055);
        cfg_read(6'h0F, d, v);
        check({31'b0, v}, 32'h0, "R4 no rvalid in preload");
        go_active();
        check({31'b0, cfg_ready}, 32'h1, "R3 ready after done");
        read_check(6'h0F, "R4 preload write ignored / R12 line");
        // R1 reset values, R2 no preload
        read_check(6'h01, "R1 cmd status reset");
        read_check(6'h04, "R1 bar reset");
        read_check(6'h00, "R2 ident zero without preload");
        read_check(6'h0B, "R2 subsys zero without preload");
        // R2 with preload
        do_reset();
        preload(1'b0, 32'hBEEF_13A8);
        preload(1'b1, 32'h1234_5678);
        m_id = 32'hBEEF_13A8; m_sub = 32'h1234_5678;
        go_active();
        read_check(6'h00, "R2 ident preloaded");
        read_check(6'h0B, "R2 subsys preloaded");
        // R3 frozen
        preload(1'b0, 32'hDEAD_DEAD);
        cfg_write(6'h00, 4'hF, 32'hFFFF_FFFF);
        cfg_write(6'h0B, 4'hF, 32'hFFFF_FFFF);
        read_check(6'h00, "R3 ident frozen");
        read_check(6'h0B, "R3 subsys frozen");
        // R9, R11
        cfg_write(6'h02, 4'hF, 32'hFFFF_FFFF);
        read_check(6'h02, "R9 class rev");
        cfg_write(6'h03, 4'hF, 32'hFFFF_FFFF);
        read_check(6'h03, "R9 hdr word zero");
        for (int a = 5; a < 64; a++) begin
            if (a == 6'h0B || a == 6'h0F) continue;
            if (a % 7 == 0) cfg_write(a[5:0], 4'hF, 32'hFFFF_FFFF);
            read_check(a[5:0], "R11 unimplemented zero");
        end
        // R6 byte enables and bit 0
        cfg_write(6'h01, 4'h1, 32'hFFFF_FFFF);
        model_write(6'h01, 4'h1, 32'hFFFF_FFFF);
        read_check(6'h01, "R6 byte0 only");
        check({31'b0, perr_en}, 32'h1, "R6 perr_en");
        check({31'b0, serr_en}, 32'h0, "R6 serr_en off");
        cfg_write(6'h01, 4'h2, 32'h0000_0100);
        model_write(6'h01, 4'h2, 32'h0000_0100);
        read_check(6'h01, "R6 byte1 serr");
        check({31'b0, serr_en}, 32'h1, "R6 serr_en on");
        // R7 set, write-0, clear, set-wins
        @(negedge clk);
        par_err_evt = 1; sys_err_evt = 1; tabort_evt = 1;
        @(negedge clk);
        par_err_evt = 0; sys_err_evt = 0; tabort_evt = 0;
        m_spe = 1; m_sse = 1; m_sta = 1;
        read_check(6'h01, "R7 status set");
        cfg_write(6'h01, 4'h8, 32'h0000_0000);
        read_check(6'h01, "R7 write zero keeps");
        cfg_write(6'h01, 4'h7, 32'hFFFF_FFFF);
        model_write(6'h01, 4'h7, 32'hFFFF_FFFF);
        read_check(6'h01, "R7 no clear without be3");
        cfg_write(6'h01, 4'h8, 32'h4800_0000);
        model_write(6'h01, 4'h8, 32'h4800_0000);
        read_check(6'h01, "R7 clear sse sta");
        @(negedge clk);
        cfg_wr = 1; cfg_addr = 6'h01; cfg_be = 4'h8; cfg_wdata = 32'h8000_0000;
        par_err_evt = 1;
        @(negedge clk);
        cfg_wr = 0; par_err_evt = 0;
        read_check(6'h01, "R7 set wins over clear");
        // R8 other status bits zero even if written
        cfg_write(6'h01, 4'hC, 32'h37FF_0000);
        read_check(6'h01, "R8 status fixed bits");
        // R10 BAR and R13 hit
        cfg_write(6'h04, 4'hF, 32'hA5A5_AFFF);
        model_write(6'h04, 4'hF, 32'hA5A5_AFFF);
        read_check(6'h04, "R10 bar write");
        hit_check(20'hA5A5A, "R13 hit");
        hit_check(20'hA5A5B, "R13 miss");
        cfg_write(6'h01, 4'h1, 32'h0);
        model_write(6'h01, 4'h1, 32'h0);
        hit_check(20'hA5A5A, "R13 disabled");
        // R5 and mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic [5:0] a; logic [3:0] be; logic [31:0] dd;
            case ($urandom % 4)
                0: a = 6'h01;
                1: a = 6'h04;
                2: a = 6'h0F;
                default: a = 6'($urandom % 64);
            endcase
            be = 4'($urandom); dd = $urandom;
            if ($urandom % 2) begin
                cfg_write(a, be, dd);
                model_write(a, be, dd);
            end else begin
                read_check(a, "R5 random read");
            end
            if (i % 8 == 0) hit_check(($urandom % 2) ? m_bar[31:12] : 20'($urandom), "R13 random");
        end
        // R1 again after reset mid-run
        do_reset();
        go_active();
        read_check(6'h01, "R1 cmd after second reset");
        read_check(6'h0F, "R1 line after second reset");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule